// File: doc/BRIEF.md
# Character I/O and Single-Level Interrupt Controller

This block sits beside the control unit of a small accumulator machine with 16-bit words and 12-bit addresses. It owns an 8-bit input channel (a keyboard-like source) and an 8-bit output channel (a printer-like sink). Each channel has a one-character buffer and a ready flag. The block executes the six I/O instructions that the control unit hands it, and it runs the machine's single interrupt level.

The control unit raises `io_exec_i` for one cycle when it executes an I/O instruction, and it presents that instruction on `instr_i`. The block answers in the same cycle with an accumulator load, a program-counter increment for a skip, or neither. Flag and enable changes take effect on the next edge.

The block also watches the shared sequence counter on `step_i`. It raises `int_req_o` only between fetches. While `int_req_o` is high, the control unit replaces its fetch with three interrupt steps, and the block drives the control strobes for each step. Those steps save the return address in word 0 and leave the program counter at 1, where a branch to the handler is expected. Both peripheral sides use a valid/ready handshake.

Top module: `chario_irq_ctrl`

## Requirements
- R1: After reset, the interrupt enable, the interrupt request and both flags are 0. This means `in_ready_o`=1, `out_valid_o`=0, `int_req_o`=0 and `int_en_o`=0.
- R2: A character is taken only while the input flag is clear. When `in_valid_i` and `in_ready_o` are both high, the buffer loads `in_data_i` and the flag sets, so `in_ready_o` is 0 from the next cycle. While the flag is set, offered characters are ignored and the buffer keeps its value.
- R3: The input-take instruction is 16'hF800, with bit 11 set under prefix 4'hF. With `io_exec_i` high, it drives `ac_load_o`=1 and `ac_data_o` = buffer in that cycle, and it clears the input flag on the next edge. If a character is accepted in the same cycle, the arrival wins and the flag stays set.
- R4: The output-put instruction is 16'hF400 (bit 10). It copies `ac_lo_i` into the output buffer and clears the output flag. From the next cycle, `out_valid_o`=1 and `out_data_o` holds that byte.
- R5: When `out_valid_o` and `out_ready_i` are both high, the output flag sets and `out_valid_o` falls on the next cycle.
- R6: The skip-on-input instruction is 16'hF200 (bit 9) and the skip-on-output instruction is 16'hF100 (bit 8). Each drives `pc_inc_o`=1 in its execute cycle exactly when its flag is 1.
- R7: The enable instruction 16'hF080 (bit 7) sets the interrupt enable, and the disable instruction 16'hF040 (bit 6) clears it. The new value is visible on `int_en_o` in the next cycle.
- R8: `int_req_o` rises one cycle after a cycle in which all three hold: the enable is 1, either flag is 1, and `step_i` is 3 or more. It never rises after a cycle with `step_i` in 0..2.
- R9: In interrupt step 0 (`int_req_o`=1, `step_i`=0), `ar_clr_o`=1 and the save register captures `pc_i`.
- R10: In interrupt step 1, `mem_we_o`=1, `mem_wdata_o` = the `pc_i` captured in step 0, and `pc_clr_o`=1. The target address is 0, set by the clear in step 0.
- R11: In interrupt step 2, `pc_inc_o`=1 and `sc_clr_o`=1. On the next cycle `int_req_o`=0 and `int_en_o`=0, so execution resumes at word 1.
- R12: Nothing is executed when `io_exec_i` is 0 or when the high nibble of `instr_i` is not 4'hF. In those cases `ac_load_o`, `pc_inc_o` and the flags are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_exec_i | input | 1 | Execute strobe for the instruction on instr_i |
| instr_i | input | 16 | Current instruction word |
| ac_lo_i | input | 8 | Low byte of the accumulator |
| step_i | input | 4 | Control unit sequence counter value |
| pc_i | input | 12 | Current program counter |
| in_valid_i | input | 1 | Input source offers a character |
| in_data_i | input | 8 | Offered character |
| in_ready_o | output | 1 | Input buffer empty (flag clear) |
| out_valid_o | output | 1 | Output buffer holds a character for the sink |
| out_data_o | output | 8 | Output buffer |
| out_ready_i | input | 1 | Sink accepts the character |
| ac_load_o | output | 1 | Load low accumulator byte from ac_data_o |
| ac_data_o | output | 8 | Input buffer contents |
| pc_inc_o | output | 1 | Increment program counter (skip or interrupt step 2) |
| int_en_o | output | 1 | Interrupt enable state |
| int_req_o | output | 1 | Interrupt cycle in force, replaces fetch |
| ar_clr_o | output | 1 | Clear address register (interrupt step 0) |
| mem_we_o | output | 1 | Write memory (interrupt step 1) |
| mem_wdata_o | output | 12 | Return address to store |
| pc_clr_o | output | 1 | Clear program counter (interrupt step 1) |
| sc_clr_o | output | 1 | Clear sequence counter (interrupt step 2) |

## Verification
Some rules are checked on every cycle. The request must never rise after a fetch step, the stored word must equal the program counter seen one step earlier, and the interrupt exit must drop both request and enable. The channel handshakes are also checked on every cycle: acceptance, take, put and drain. Other behaviour can only be shown by the bench's scenarios: the ignored second character, the skip decisions against each flag, and the return address and resume point of an interrupt taken mid-program. Those scenarios use a small control-unit model together with random mixes of instructions and peripheral traffic.

// File: rtl/chario_pkg.sv
package chario_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [3:0] IO_PREFIX = 4'hF;
  localparam int unsigned BIT_INP = 11;
  localparam int unsigned BIT_OUT = 10;
  localparam int unsigned BIT_SKI = 9;
  localparam int unsigned BIT_SKO = 8;
  localparam int unsigned BIT_ION = 7;
  localparam int unsigned BIT_IOF = 6;

  typedef struct packed {
    logic take;
    logic put;
    logic skip_in;
    logic skip_out;
    logic en_set;
    logic en_clr;
  } io_cmd_t;

  function automatic io_cmd_t io_decode(input logic exec, input logic [WORD_W-1:0] ins);
    io_cmd_t c;
    logic hit;
    hit        = exec && (ins[WORD_W-1 -: 4] == IO_PREFIX);
    c.take     = hit && ins[BIT_INP];
    c.put      = hit && ins[BIT_OUT];
    c.skip_in  = hit && ins[BIT_SKI];
    c.skip_out = hit && ins[BIT_SKO];
    c.en_set   = hit && ins[BIT_ION];
    c.en_clr   = hit && ins[BIT_IOF];
    return c;
  endfunction
endpackage

// File: rtl/chario_in_chan.sv
module chario_in_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              flag_o,
  output logic [DATA_W-1:0] buf_o
);
  logic accept;
  assign accept = valid_i && !flag_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      buf_o  <= '0;
    end else begin
      if (accept) begin
        flag_o <= 1'b1;
        buf_o  <= data_i;
      end else if (take_i) begin
        flag_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chario_out_chan.sv
module chario_out_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              put_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              flag_o,
  output logic              pend_o,
  output logic [DATA_W-1:0] buf_o
);
  logic done;
  assign done = pend_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      pend_o <= 1'b0;
      buf_o  <= '0;
    end else begin
      if (put_i) begin
        flag_o <= 1'b0;
        pend_o <= 1'b1;
        buf_o  <= data_i;
      end else if (done) begin
        flag_o <= 1'b1;
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chario_int_seq.sv
module chario_int_seq #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic              fgi_i,
  input  logic              fgo_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              ien_o,
  output logic              req_o,
  output logic              ar_clr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  output logic              pc_clr_o,
  output logic              pc_inc_o,
  output logic              sc_clr_o
);
  localparam logic [STEP_W-1:0] STEP_SAVE = STEP_W'(0);
  localparam logic [STEP_W-1:0] STEP_WRITE = STEP_W'(1);
  localparam logic [STEP_W-1:0] STEP_DONE = STEP_W'(2);

  logic [ADDR_W-1:0] tr_q;
  logic              in_save, in_write, in_done;

  assign in_save  = req_o && (step_i == STEP_SAVE);
  assign in_write = req_o && (step_i == STEP_WRITE);
  assign in_done  = req_o && (step_i == STEP_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_o <= 1'b0;
      req_o <= 1'b0;
      tr_q  <= '0;
    end else begin
      if (in_done) begin
        ien_o <= 1'b0;
        req_o <= 1'b0;
      end else begin
        if (en_set_i)      ien_o <= 1'b1;
        else if (en_clr_i) ien_o <= 1'b0;
        // only between fetches
        if (!req_o && ien_o && (fgi_i || fgo_i) && (step_i > STEP_DONE)) req_o <= 1'b1;
      end
      if (in_save) tr_q <= pc_i;
    end
  end

  assign ar_clr_o    = in_save;
  assign mem_we_o    = in_write;
  assign mem_wdata_o = tr_q;
  assign pc_clr_o    = in_write;
  assign pc_inc_o    = in_done;
  assign sc_clr_o    = in_done;
endmodule

// File: rtl/chario_irq_ctrl.sv
module chario_irq_ctrl
  import chario_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_exec_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [DATA_W-1:0] ac_lo_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              ac_load_o,
  output logic [DATA_W-1:0] ac_data_o,
  output logic              pc_inc_o,
  output logic              int_en_o,
  output logic              int_req_o,
  output logic              ar_clr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  output logic              pc_clr_o,
  output logic              sc_clr_o
);
  io_cmd_t cmd;
  logic    fgi, fgo, int_pc_inc;

  assign cmd = io_decode(io_exec_i, instr_i);

  chario_in_chan #(.DATA_W(DATA_W)) in_chan_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .data_i (in_data_i),
    .take_i (cmd.take),
    .flag_o (fgi),
    .buf_o  (ac_data_o)
  );

  chario_out_chan #(.DATA_W(DATA_W)) out_chan_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .put_i  (cmd.put),
    .data_i (ac_lo_i),
    .ready_i(out_ready_i),
    .flag_o (fgo),
    .pend_o (out_valid_o),
    .buf_o  (out_data_o)
  );

  chario_int_seq #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) int_seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_set_i   (cmd.en_set),
    .en_clr_i   (cmd.en_clr),
    .fgi_i      (fgi),
    .fgo_i      (fgo),
    .step_i     (step_i),
    .pc_i       (pc_i),
    .ien_o      (int_en_o),
    .req_o      (int_req_o),
    .ar_clr_o   (ar_clr_o),
    .mem_we_o   (mem_we_o),
    .mem_wdata_o(mem_wdata_o),
    .pc_clr_o   (pc_clr_o),
    .pc_inc_o   (int_pc_inc),
    .sc_clr_o   (sc_clr_o)
  );

  assign in_ready_o = !fgi;
  assign ac_load_o  = cmd.take;
  assign pc_inc_o   = int_pc_inc || (cmd.skip_in && fgi) || (cmd.skip_out && fgo);
endmodule

// File: rtl/chario_irq_ctrl_chk.sv
module chario_irq_ctrl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned STEP_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_exec_i,
  input logic [15:0]       instr_i,
  input logic [DATA_W-1:0] ac_lo_i,
  input logic [STEP_W-1:0] step_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ready_i,
  input logic              int_en_o,
  input logic              int_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_wdata_o
);
  logic is_take, is_put;
  assign is_take = io_exec_i && (instr_i == 16'hF800);
  assign is_put  = io_exec_i && (instr_i == 16'hF400);

  AST_IN_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o); // R2
  AST_IN_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_take && !in_ready_o) |=> in_ready_o); // R3
  AST_OUT_PUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_put |=> (out_valid_o && out_data_o == $past(ac_lo_i))); // R4
  AST_OUT_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !is_put) |=> !out_valid_o); // R5
  AST_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_req_o) |-> ($past(step_i) > STEP_W'(2) && $past(int_en_o))); // R8
  AST_SAVE_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(int_req_o)) |-> (mem_wdata_o == $past(pc_i))); // R10
  AST_INT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_req_o && step_i == STEP_W'(2)) |=> (!int_req_o && !int_en_o)); // R11
endmodule

bind chario_irq_ctrl chario_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_exec_i  (io_exec_i),
  .instr_i    (instr_i),
  .ac_lo_i    (ac_lo_i),
  .step_i     (step_i),
  .pc_i       (pc_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .out_ready_i(out_ready_i),
  .int_en_o   (int_en_o),
  .int_req_o  (int_req_o),
  .mem_we_o   (mem_we_o),
  .mem_wdata_o(mem_wdata_o)
);

// File: tb/chario_irq_ctrl_tb_top.sv
module chario_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_exec = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  ac_lo = '0;
  logic [3:0]  step = 4'd1;
  logic [11:0] pc = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_ready = 1'b0;
  logic [7:0]  out_data, ac_data;
  logic        ac_load, pc_inc, int_en, int_req, ar_clr, mem_we, pc_clr, sc_clr;
  logic [11:0] mem_wdata;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  chario_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_exec_i(io_exec), .instr_i(instr), .ac_lo_i(ac_lo),
    .step_i(step), .pc_i(pc), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_ready_i(out_ready), .ac_load_o(ac_load), .ac_data_o(ac_data), .pc_inc_o(pc_inc),
    .int_en_o(int_en), .int_req_o(int_req), .ar_clr_o(ar_clr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .pc_clr_o(pc_clr), .sc_clr_o(sc_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    io_exec = 1'b0; in_valid = 1'b0; out_ready = 1'b0; instr = 16'h0000;
  endtask

  task automatic exec(input logic [15:0] ins);
    io_exec = 1'b1; instr = ins;
  endtask

  // reference model
  logic       m_fgi, m_fgo, m_pend, m_ien;
  logic [7:0] m_inpr, m_outr;

  function automatic logic exp_skip(input logic ex, input logic [15:0] ins, input logic fi, input logic fo);
    return ex && ins[15:12] == 4'hF && ((ins[9] && fi) || (ins[8] && fo));
  endfunction

  function automatic logic exp_take(input logic ex, input logic [15:0] ins);
    return ex && ins[15:12] == 4'hF && ins[11];
  endfunction

  logic [11:0] cpu_pc;
  logic [11:0] mem0;

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    eq("R1 in_ready", in_ready, 1);
    eq("R1 out_valid", out_valid, 0);
    eq("R1 int_req", int_req, 0);
    eq("R1 int_en", int_en, 0);
    rst_n = 1'b1;
    tick();
    eq("R1 int_req after release", int_req, 0);

    // R2 accept then ignore while full
    step = 4'd3;
    in_valid = 1'b1; in_data = 8'h41;
    tick();
    eq("R2 in_ready low after accept", in_ready, 0);
    in_data = 8'h55;
    tick();
    in_valid = 1'b0;
    eq("R2 still full", in_ready, 0);
    // R3 take
    exec(16'hF800);
    #1;
    eq("R3 ac_load", ac_load, 1);
    eq("R2 second char ignored", ac_data, 8'h41);
    tick();
    idle();
    eq("R3 flag cleared", in_ready, 1);

    // R12 not executed
    instr = 16'hF800; io_exec = 1'b0;
    #1 eq("R12 no exec no load", ac_load, 0);
    exec(16'h7800);
    #1 eq("R12 non-io no load", ac_load, 0);
    eq("R12 non-io no skip", pc_inc, 0);
    exec(16'h7200);
    #1 eq("R12 non-io prefix ignored", ac_load, 0);
    tick();
    idle();
    eq("R12 flag unchanged", in_ready, 1);

    // R4 put
    ac_lo = 8'h5A;
    exec(16'hF400);
    tick();
    idle();
    eq("R4 out_valid", out_valid, 1);
    eq("R4 out_data", out_data, 8'h5A);
    tick();
    eq("R5 held while not ready", out_valid, 1);
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
    eq("R5 drained", out_valid, 0);

    // R6 skips
    exec(16'hF100);
    #1 eq("R6 skip on output flag", pc_inc, 1);
    exec(16'hF200);
    #1 eq("R6 no skip input flag clear", pc_inc, 0);
    tick();
    idle();

    // R7 and R8 gating during fetch steps
    step = 4'd1;
    exec(16'hF080);
    tick();
    idle();
    eq("R7 enable set", int_en, 1);
    for (int s = 0; s < 3; s++) begin
      step = 4'(s);
      tick();
      eq("R8 no request during fetch step", int_req, 0);
    end
    step = 4'd3;
    tick();
    eq("R8 request raised", int_req, 1);

    // R9..R11 interrupt cycle driven by control unit model
    cpu_pc = 12'h100;
    mem0 = 12'h000;
    step = 4'd0; pc = cpu_pc;
    #1 eq("R9 ar_clr in step 0", ar_clr, 1);
    eq("R9 no write in step 0", mem_we, 0);
    tick();
    step = 4'd1; pc = 12'h3FF;
    #1 eq("R10 mem_we", mem_we, 1);
    eq("R10 saved pc", mem_wdata, 12'h100);
    eq("R10 pc_clr", pc_clr, 1);
    if (mem_we) mem0 = mem_wdata;
    if (pc_clr) cpu_pc = 12'h000;
    tick();
    step = 4'd2; pc = cpu_pc;
    #1 eq("R11 pc_inc", pc_inc, 1);
    eq("R11 sc_clr", sc_clr, 1);
    if (pc_inc) cpu_pc = cpu_pc + 12'd1;
    tick();
    step = 4'd0;
    eq("R11 request cleared", int_req, 0);
    eq("R11 enable cleared", int_en, 0);
    eq("R11 return address in word 0", mem0, 12'h100);
    eq("R11 resume at word 1", cpu_pc, 12'h001);

    // R7 disable
    step = 4'd1;
    exec(16'hF080);
    tick();
    exec(16'hF040);
    tick();
    idle();
    eq("R7 enable cleared", int_en, 0);

    // random mix, step held in fetch so R8 keeps request low
    m_fgi = 1'b0; m_inpr = 8'h41; m_fgo = 1'b1; m_pend = 1'b0; m_outr = 8'h5A; m_ien = 1'b0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ins;
      logic ex, acc, tk, pt, dn;
      case ($urandom_range(0, 6))
        0: ins = 16'hF800;
        1: ins = 16'hF400;
        2: ins = 16'hF200;
        3: ins = 16'hF100;
        4: ins = 16'hF080;
        5: ins = 16'hF040;
        default: ins = 16'h7020;
      endcase
      ex = ($urandom_range(0, 2) == 0);
      io_exec = ex; instr = ins;
      in_valid = $urandom_range(0, 1); in_data = 8'($urandom);
      out_ready = $urandom_range(0, 1); ac_lo = 8'($urandom);
      #1;
      eq("R2 in_ready", in_ready, !m_fgi);
      eq("R4 out_valid", out_valid, m_pend);
      eq("R4 out_data", out_data, m_outr);
      eq("R6 skip", pc_inc, exp_skip(ex, ins, m_fgi, m_fgo));
      eq("R3 ac_load", ac_load, exp_take(ex, ins));
      eq("R3 ac_data", ac_data, m_inpr);
      eq("R7 int_en", int_en, m_ien);
      eq("R8 no request", int_req, 0);
      acc = in_valid && !m_fgi;
      tk = exp_take(ex, ins);
      pt = ex && ins[15:12] == 4'hF && ins[10];
      dn = m_pend && out_ready;
      if (acc) begin m_fgi = 1'b1; m_inpr = in_data; end
      else if (tk) m_fgi = 1'b0;
      if (pt) begin m_fgo = 1'b0; m_pend = 1'b1; m_outr = ac_lo; end
      else if (dn) begin m_fgo = 1'b1; m_pend = 1'b0; end
      if (ex && ins[7]) m_ien = 1'b1;
      else if (ex && ins[6]) m_ien = 1'b0;
      tick();
    end
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule